// File: doc/BRIEF.md
# Dual-Width Byte-Serial CRC Calculator

This block computes a running cyclic redundancy check over a byte stream written to it one byte at a time through a small register bus. At run time a control bit chooses between a 16-bit generator (0x1021) and a 32-bit generator (0x04C11DB7). A second bit chooses whether the result starts from all zeros or all ones. Writing the initialize bit loads that starting value.

Every byte written to the input register folds into the result in the cycle it is written. Bits are taken most significant first, with no reflection and no final inversion. The result is not exposed as a wide word. Software reaches it one byte at a time through a data register, and an internal byte pointer picks the byte. The pointer advances after each access to the data register. It can also be set directly, and it returns to zero on initialize. The same data register can overwrite result bytes, which lets software seed the result with any value.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset the result is 0, the byte pointer is 0, and the control register reads 0, which selects 32-bit mode with the all-zeros preset.
- R2: With width bit (control bit 0) = 1, each input byte updates the low 16 bits of the result using generator 0x1021, most significant bit first. Example: ASCII "123456789" from a zero preset gives 0x31C3, and from an all-ones preset gives 0x29B1.
- R3: With width bit = 0, each input byte updates the 32-bit result using generator 0x04C11DB7, most significant bit first. Example: "123456789" from an all-ones preset gives 0x0376E6E7.
- R4: Control reads return bit 0 = width select and bit 1 = preset select, as last written. Bit 2 and the upper bits always read 0.
- R5: A control write with bit 2 = 1 loads the preset chosen by that same write into the result and clears the pointer. The preset is 0 for preset bit 0. For preset bit 1 it is 0xFFFFFFFF in 32-bit mode and 0x0000FFFF in 16-bit mode.
- R6: A write to the input register (address 1) updates the result on the same clock edge, so a read issued in the next cycle already returns the updated byte. Reads of address 1 return 0.
- R7: A read of the data register (address 3) returns result byte number `pointer`, where byte 0 is bits 7:0, and then advances the pointer. The pointer wraps modulo 4 in 32-bit mode and modulo 2 in 16-bit mode.
- R8: A write to the data register replaces the result byte under the pointer, leaves the other bytes unchanged, and advances the pointer.
- R9: A write to the pointer register (address 2) sets the pointer to its low bits: two bits in 32-bit mode, one bit in 16-bit mode. A read of address 2 returns the pointer.
- R10: The result does not change on control writes that leave bit 2 at 0, on pointer accesses, or on reads.
- R11: In 16-bit mode, result bits 31:16 are 0 after every input byte.
- R12: Read data appears on `rdata`, with `rd_valid` high, in the cycle after the read is issued. When `wr_en` and `rd_en` are high together, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 input byte, 2 pointer, 3 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rd_valid | output | 1 | High for one cycle when rdata holds a new read result |

## Verification
The bench checks the known check values for all three preset and width combinations, so a wrong bit order, a wrong generator or reflected bits would give wrong bytes. It switches from 16-bit to 32-bit mode without initializing and reads all four bytes. A design that leaves stale upper bits, or that disturbs the result on a control write, shows this as non-zero bytes 2 and 3. The pointer wrap is checked by reading past the last byte in each mode, and a pointer that wraps at the wrong count would return the wrong byte. The bench also checks that initialize clears the pointer, that pointer writes are masked in 16-bit mode, and that a data write changes only the byte under the pointer. It then runs a pseudo-random byte stream in both modes against its own shift-register model.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int BYTE_W  = 8;
  localparam int WIDE_W  = 32;
  localparam int NARROW_W = 16;
  localparam int NBYTES  = WIDE_W / BYTE_W;
  localparam int PTR_W   = $clog2(NBYTES);

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DIN  = 2'd1,
    REG_PTR  = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;

  localparam int CTL_NARROW_BIT = 0;
  localparam int CTL_ONES_BIT   = 1;
  localparam int CTL_INIT_BIT   = 2;

  // One byte through the selected generator, most significant bit first.
  function automatic logic [WIDE_W-1:0] crc_byte_step(
      input logic [WIDE_W-1:0]   cur,
      input logic [BYTE_W-1:0]   din,
      input logic                narrow,
      input logic [WIDE_W-1:0]   poly_wide,
      input logic [NARROW_W-1:0] poly_narrow);
    logic [WIDE_W-1:0]   cw;
    logic [NARROW_W-1:0] cn;
    logic                fw;
    logic                fn;
    cw = cur;
    cn = cur[NARROW_W-1:0];
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fw = cw[WIDE_W-1] ^ din[i];
      fn = cn[NARROW_W-1] ^ din[i];
      cw = {cw[WIDE_W-2:0], 1'b0} ^ (fw ? poly_wide : '0);
      cn = {cn[NARROW_W-2:0], 1'b0} ^ (fn ? poly_narrow : '0);
    end
    return narrow ? {{(WIDE_W-NARROW_W){1'b0}}, cn} : cw;
  endfunction

  function automatic logic [WIDE_W-1:0] preset_value(input logic narrow, input logic ones);
    logic [WIDE_W-1:0] v;
    if (!ones)       v = '0;
    else if (narrow) v = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    else             v = '1;
    return v;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_mask(input logic narrow);
    logic [PTR_W-1:0] m;
    m = narrow ? PTR_W'((NARROW_W / BYTE_W) - 1) : PTR_W'(NBYTES - 1);
    return m;
  endfunction

endpackage

// File: rtl/crc_mode_reg.sv
module crc_mode_reg
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              narrow,
  output logic              ones,
  output logic              init_evt,
  output logic              init_narrow,
  output logic              init_ones
);

  assign init_evt    = ctrl_wr && wdata[CTL_INIT_BIT];
  assign init_narrow = wdata[CTL_NARROW_BIT];
  assign init_ones   = wdata[CTL_ONES_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      narrow <= 1'b0;
      ones   <= 1'b0;
    end else if (ctrl_wr) begin
      narrow <= wdata[CTL_NARROW_BIT];
      ones   <= wdata[CTL_ONES_BIT];
    end
  end

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(narrow) && $stable(ones)));

endmodule

// File: rtl/crc_byte_ptr.sv
module crc_byte_ptr
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             narrow,
  input  logic             init_evt,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             step_evt,
  output logic [PTR_W-1:0] byte_idx
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] mask;

  assign mask     = ptr_mask(narrow);
  assign byte_idx = ptr_q & mask;

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= '0;
    else if (init_evt) ptr_q <= '0;
    else if (ptr_wr)   ptr_q <= ptr_wdata & mask;
    else if (step_evt) ptr_q <= (byte_idx + PTR_W'(1)) & mask;
  end

  // R5
  init_ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> (byte_idx == '0));

  // R7
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !init_evt && !ptr_wr && $stable(narrow)) |=>
      (byte_idx == (($past(byte_idx) + PTR_W'(1)) & mask)));

  // R9
  ptr_narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> (byte_idx < PTR_W'(NARROW_W / BYTE_W)));

endmodule

// File: rtl/crc_result_core.sv
module crc_result_core
  import crc_pkg::*;
#(
  parameter logic [WIDE_W-1:0]   POLY_WIDE   = 32'h04C11DB7,
  parameter logic [NARROW_W-1:0] POLY_NARROW = 16'h1021
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              init_evt,
  input  logic              init_narrow,
  input  logic              init_ones,
  input  logic              din_evt,
  input  logic [BYTE_W-1:0] din_byte,
  input  logic              byte_wr,
  input  logic [PTR_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [WIDE_W-1:0] result
);

  logic [WIDE_W-1:0] next_crc;
  logic [WIDE_W-1:0] patched;

  assign next_crc = crc_byte_step(result, din_byte, narrow, POLY_WIDE, POLY_NARROW);

  always_comb begin
    patched = result;
    patched[{byte_idx, 3'b000} +: BYTE_W] = byte_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        result <= '0;
    else if (init_evt) result <= preset_value(init_narrow, init_ones);
    else if (din_evt)  result <= next_crc;
    else if (byte_wr)  result <= patched;
  end

  // R5
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> ((result == '0) || (result == '1) ||
                  (result == {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}})));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_evt && !din_evt && !byte_wr) |=> $stable(result));

  // R11
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_evt && !init_evt && narrow) |=> (result[WIDE_W-1:NARROW_W] == '0));

  // R8
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !init_evt && !din_evt) |=>
      (result[{$past(byte_idx), 3'b000} +: BYTE_W] == $past(byte_data)));

endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_pkg::*;
#(
  parameter logic [31:0] POLY_WIDE   = 32'h04C11DB7,
  parameter logic [15:0] POLY_NARROW = 16'h1021
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid
);

  logic              rd_acc;
  logic              ctrl_wr, din_wr, ptr_wr, dat_wr, dat_rd, step_evt;
  logic              narrow, ones, init_evt, init_narrow, init_ones;
  logic [PTR_W-1:0]  byte_idx;
  logic [WIDE_W-1:0] result;
  logic [BYTE_W-1:0] rd_mux;

  assign rd_acc   = rd_en && !wr_en;
  assign ctrl_wr  = wr_en && (addr == REG_CTRL);
  assign din_wr   = wr_en && (addr == REG_DIN);
  assign ptr_wr   = wr_en && (addr == REG_PTR);
  assign dat_wr   = wr_en && (addr == REG_DATA);
  assign dat_rd   = rd_acc && (addr == REG_DATA);
  assign step_evt = dat_wr || dat_rd;

  crc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .narrow(narrow), .ones(ones), .init_evt(init_evt),
    .init_narrow(init_narrow), .init_ones(init_ones)
  );

  crc_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .init_evt(init_evt),
    .ptr_wr(ptr_wr), .ptr_wdata(wdata[PTR_W-1:0]), .step_evt(step_evt),
    .byte_idx(byte_idx)
  );

  crc_result_core #(.POLY_WIDE(POLY_WIDE), .POLY_NARROW(POLY_NARROW)) u_core (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .init_evt(init_evt),
    .init_narrow(init_narrow), .init_ones(init_ones),
    .din_evt(din_wr), .din_byte(wdata),
    .byte_wr(dat_wr), .byte_idx(byte_idx), .byte_data(wdata),
    .result(result)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      REG_CTRL: begin
        rd_mux[CTL_NARROW_BIT] = narrow;
        rd_mux[CTL_ONES_BIT]   = ones;
      end
      REG_DIN:  rd_mux = '0;
      REG_PTR:  rd_mux[PTR_W-1:0] = byte_idx;
      REG_DATA: rd_mux = result[{byte_idx, 3'b000} +: BYTE_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rdata <= rd_mux;
    end
  end

  // R12
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en && !wr_en));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(rdata));

endmodule

// File: tb/tb_crc_byte_engine.sv
module tb_crc_byte_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  logic [31:0] m_crc = '0;
  logic [1:0]  m_ptr = '0;
  bit          m_nar = 0;
  bit          m_one = 0;

  always #2 clk = ~clk;

  crc_byte_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  // shift-register model: byte xored into the top, then eight shifts
  function automatic logic [31:0] m_step(logic [31:0] c, logic [7:0] b, bit nar);
    int w;
    logic [31:0] p;
    logic [31:0] keep;
    w    = nar ? 16 : 32;
    p    = nar ? 32'h0000_1021 : 32'h04C1_1DB7;
    keep = nar ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    c = (c & keep) ^ ({24'h0, b} << (w - 8));
    for (int k = 0; k < 8; k++) begin
      if (c[w-1]) c = ((c << 1) ^ p) & keep;
      else        c = (c << 1) & keep;
    end
    return c;
  endfunction

  function automatic logic [1:0] m_msk();
    return m_nar ? 2'd1 : 2'd3;
  endfunction

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    logic [1:0] p;
    @(negedge clk);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    p = m_ptr & m_msk();
    case (a)
      2'd0: begin
        m_nar = d[0]; m_one = d[1];
        if (d[2]) begin
          m_crc = d[1] ? (d[0] ? 32'h0000_FFFF : 32'hFFFF_FFFF) : 32'h0;
          m_ptr = 0;
        end
      end
      2'd1: m_crc = m_step(m_crc, d, m_nar);
      2'd2: m_ptr = d[1:0] & m_msk();
      default: begin
        m_crc[p*8 +: 8] = d;
        m_ptr = (p + 2'd1) & m_msk();
      end
    endcase
  endtask

  // read with expected value from the model
  task automatic bus_rd(input logic [1:0] a, input string tag);
    logic [7:0] e;
    logic [1:0] p;
    p = m_ptr & m_msk();
    case (a)
      2'd0: e = {6'b0, m_one, m_nar};
      2'd1: e = 8'h00;
      2'd2: e = {6'b0, p};
      default: begin
        e = m_crc[p*8 +: 8];
        m_ptr = (p + 2'd1) & m_msk();
      end
    endcase
    bus_rd_exp(a, e, tag);
  endtask

  // read with an explicitly given expected value (model pointer still tracked by caller)
  task automatic bus_rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    wr_en = 0; rd_en = 1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic feed_digits();
    for (int i = 0; i < 9; i++) bus_wr(2'd1, 8'h31 + 8'(i));
  endtask

  // read back data bytes with fixed expectations, advancing the model pointer
  task automatic rd_known(input logic [31:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      bus_rd_exp(2'd3, v[i*8 +: 8], tag);
      m_ptr = (m_ptr + 2'd1) & m_msk();
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected read data got %02h exp none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s got %02h exp %02h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired got hung exp finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    bus_rd(2'd0, "R1 ctrl");
    bus_rd(2'd2, "R1 ptr");
    for (int i = 0; i < 4; i++) bus_rd(2'd3, "R1 result byte");
    // R7: wrapped modulo 4 after four reads
    bus_rd(2'd2, "R7 wrap32 ptr");

    // R5: init clears the pointer
    bus_rd(2'd3, "R7 advance");
    bus_wr(2'd0, 8'b110);
    bus_rd(2'd2, "R5 ptr cleared");
    bus_rd(2'd0, "R4 ctrl readback");
    rd_known(32'hFFFF_FFFF, 4, "R5 preset ones 32");

    // R3: 32-bit check value
    feed_digits();
    rd_known(32'h0376_E6E7, 4, "R3 check value");

    // R2: 16-bit zero preset, wrap modulo 2
    bus_wr(2'd0, 8'b101);
    bus_rd(2'd0, "R4 ctrl narrow");
    feed_digits();
    rd_known(32'h0000_31C3, 2, "R2 check value zero preset");
    bus_rd(2'd3, "R7 wrap16");

    // R5: 16-bit ones preset is 0xFFFF
    bus_wr(2'd0, 8'b111);
    rd_known(32'h0000_FFFF, 2, "R5 preset ones 16");
    // R6: byte visible in the next cycle
    bus_wr(2'd1, 8'h31);
    bus_rd(2'd3, "R6 immediate update");
    bus_rd(2'd1, "R6 input reads zero");
    bus_wr(2'd0, 8'b111);
    feed_digits();
    rd_known(32'h0000_29B1, 2, "R2 check value ones preset");

    // R9: masked pointer write in 16-bit mode
    bus_wr(2'd2, 8'h03);
    bus_rd(2'd2, "R9 ptr masked 16");

    // R10, R11: switch width without init; upper bytes remain zero
    bus_wr(2'd0, 8'b000);
    bus_wr(2'd2, 8'h00);
    rd_known(32'h0000_29B1, 4, "R11 R10 upper zero after width switch");

    // R9: pointer write in 32-bit mode
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd2, "R9 ptr set");
    bus_rd(2'd3, "R9 byte at ptr");
    bus_rd(2'd2, "R7 ptr after read");

    // R8: data writes replace single bytes
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h11);
    bus_wr(2'd3, 8'h22);
    bus_wr(2'd3, 8'h33);
    bus_wr(2'd3, 8'h44);
    bus_rd(2'd2, "R8 ptr wrapped after writes");
    rd_known(32'h4433_2211, 4, "R8 overwrite");
    bus_wr(2'd2, 8'h01);
    bus_wr(2'd3, 8'hA5);
    bus_wr(2'd2, 8'h00);
    rd_known(32'h4433_A511, 4, "R8 single byte");
    // R3: continue from a seeded value
    bus_wr(2'd1, 8'h63);
    for (int i = 0; i < 4; i++) bus_rd(2'd3, "R3 seeded update");

    // R12: simultaneous write and read: write wins, no read data
    @(negedge clk);
    wr_en = 1; rd_en = 1; addr = 2'd2; wdata = 8'h01;
    m_ptr = 2'd1;
    bus_rd(2'd2, "R12 write wins");

    // R2 R3: pseudo-random streams in both modes
    lfsr = 8'h5A;
    for (int mode = 0; mode < 4; mode++) begin
      bus_wr(2'd0, {5'b0, 1'b1, mode[1], mode[0]});
      for (int i = 0; i < 40; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_wr(2'd1, lfsr);
      end
      for (int i = 0; i < (mode[0] ? 2 : 4); i++)
        bus_rd(2'd3, mode[0] ? "R2 random stream" : "R3 random stream");
    end

    idle();
    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 missing read data got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule